// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block sits between a requester and a mailbox shared with an embedded display microcontroller. The mailbox has four parts: a 32-bit command word with byte-wide fields, a 32-bit data word, a 17-bit user backlight level, and a doorbell bit. The sequencer sets the doorbell. The microcontroller clears it once it has taken the command.

The requester posts one of three high-level requests on a valid/ready port: select pipe, set enhancement level, or set backlight. For each request the sequencer works through a fixed order. It waits for the doorbell to read clear, writes the argument registers, writes the command word, rings the doorbell, and then waits for the doorbell to clear again. A backlight request runs a complete pipe-select pass first and a backlight pass after it. Every wait polls the doorbell at a programmable interval, with a cap on the number of attempts. When the microcontroller is flagged as not running, a request completes at once and touches nothing.

Top module: `mbox_cmd_seq`

## Requirements
- R1: `req_ready_o` is high only while the block is idle. A request held on `req_valid_i` while the block is busy is neither taken nor allowed to change the request in flight.
- R2: A request accepted while `mcu_running_i` is low, or one with kind 2'd3, gives a `done_o` pulse in the cycle right after acceptance. The command, data, user-level and doorbell outputs stay unchanged, and `timeout_o` stays low.
- R3: Bits 7:0 of the command word carry the opcode: 0x65 sets the enhancement level, 0x66 selects the pipe, and 0x67 sets the backlight. Request kinds are 0 pipe, 1 level, 2 backlight.
- R4: A pipe-select pass writes 0x0000FFFF to the data word and the controller id to command bits 15:8. The id value 255 (immediate disable) passes through unchanged. Bits 31:16 keep their previous value.
- R5: A level pass writes the level to command bits 23:16. Command bits 31:24 and 15:8, the data word and the user level keep their previous values.
- R6: A backlight request rings twice. The first ring is a full pipe-select pass as in R4. The second ring comes after the 17-bit level is in `user_lvl_o` and the frame ramp is in the data word (0 when the controller id is 0). At the second ring, command bits 7:0 read 0x67 and bits 15:8 still hold the controller id.
- R7: The doorbell is rung only after all argument and command writes of the pass are done, and only after a poll has seen the doorbell clear.
- R8: After each ring the sequencer waits for the doorbell to clear. `done_o` is a single-cycle pulse once the final clear is seen, and `timeout_o` stays low on success.
- R9: Each wait polls once on entry and then every POLL_INTERVAL cycles. If POLL_LIMIT polls in a row all see the doorbell set, the request is aborted and `timeout_o` is set. `done_o` then rises (POLL_LIMIT-1)*POLL_INTERVAL+1 cycles after the wait began.
- R10: A timeout in the wait before writing leaves the command, data and user-level outputs untouched, and the doorbell is not rung.
- R11: `timeout_o` stays set until the next request is accepted, which clears it.
- R12: The doorbell reads 0 in the cycle after `bell_clr_i` is high, unless the sequencer rings in that same cycle, in which case the ring wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request accepted when valid |
| req_kind_i | input | 2 | 0 pipe, 1 level, 2 backlight, 3 no-op |
| req_ctrl_id_i | input | 8 | Controller id |
| req_level_i | input | 8 | Enhancement level |
| req_bl_i | input | 17 | Backlight level, 1.16 fixed point |
| req_ramp_i | input | 32 | Frame ramp |
| mcu_running_i | input | 1 | Microcontroller running flag, sampled at acceptance |
| bell_clr_i | input | 1 | Doorbell clear from the microcontroller |
| bell_o | output | 1 | Doorbell |
| cmd_o | output | 32 | Command word |
| data_o | output | 32 | Data word |
| user_lvl_o | output | 17 | User backlight level |
| done_o | output | 1 | Request complete pulse |
| timeout_o | output | 1 | Sticky wait timeout |

## Verification
A skipped request must show `done_o` at the first falling edge after the accepting edge. A timed-out wait must show it exactly (POLL_LIMIT-1)*POLL_INTERVAL+1 cycles after the wait opened, and the bench measures both on a cycle counter that advances only on rising edges. Register contents are snapshotted on the falling edge where the doorbell first reads 1, so each snapshot holds the values committed before that ring. The doorbell is checked one cycle after every clear pulse. The modelled responder clears after a random delay of 0 to 4 cycles, or never when it is set to stuck.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;
  typedef enum logic [1:0] {
    REQ_PIPE   = 2'd0,
    REQ_LEVEL  = 2'd1,
    REQ_BLIGHT = 2'd2,
    REQ_NOP    = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_WAIT, ST_WR_USER, ST_WR_DATA,
    ST_WR_CMD, ST_RING, ST_POST_WAIT, ST_DONE
  } seq_st_e;

  localparam int CMD_W  = 32;
  localparam int DATA_W = 32;
  localparam int BL_W   = 17;

  localparam logic [7:0] OP_LEVEL  = 8'h65;
  localparam logic [7:0] OP_PIPE   = 8'h66;
  localparam logic [7:0] OP_BLIGHT = 8'h67;
  localparam logic [DATA_W-1:0] RAMP_BOUND = 32'h0000_FFFF;

  typedef struct packed {
    req_kind_e         kind;
    logic [7:0]        ctrl;
    logic [7:0]        level;
    logic [BL_W-1:0]   bl;
    logic [DATA_W-1:0] ramp;
  } req_t;
endpackage

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int POLL_LIMIT    = 80000,
  parameter int POLL_INTERVAL = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o,
  output logic last_o
);
  localparam int DIV_W = (POLL_INTERVAL > 1) ? $clog2(POLL_INTERVAL) : 1;
  localparam int ATT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  logic [DIV_W-1:0] div_q;
  logic [ATT_W-1:0] att_q;

  generate
    if (POLL_INTERVAL > 1) begin : g_div
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       div_q <= '0;
        else if (clr_i)    div_q <= '0;
        else if (run_i)    div_q <= (div_q == DIV_W'(POLL_INTERVAL - 1)) ? '0 : div_q + 1'b1;
      end
    end else begin : g_nodiv
      assign div_q = '0;
    end
  endgenerate

  assign tick_o = run_i && (div_q == '0);
  assign last_o = (att_q == ATT_W'(POLL_LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 att_q <= '0;
    else if (clr_i)              att_q <= '0;
    else if (tick_o && !last_o)  att_q <= att_q + 1'b1;
  end

  // R9: attempt count never passes the limit
  a_r9_att_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (att_q <= ATT_W'(POLL_LIMIT - 1)));
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic bell_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bell_o <= 1'b0;
    else if (set_i)  bell_o <= 1'b1;
    else if (clr_i)  bell_o <= 1'b0;
  end

  a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> bell_o);
  a_r12_clr_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !bell_o);
endmodule

// File: rtl/mbox_seq_fsm.sv
module mbox_seq_fsm
  import mbox_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  req_t              req_i,
  input  logic              running_i,
  output logic              req_ready_o,
  input  logic              bell_i,
  input  logic              tick_i,
  input  logic              last_i,
  output logic              timer_clr_o,
  output logic              timer_run_o,
  output logic              bell_set_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DATA_W-1:0] data_o,
  output logic [BL_W-1:0]   user_o,
  output logic              done_o,
  output logic              timeout_o
);
  seq_st_e state_q, state_d;
  req_t    req_q;
  logic    phase_bl_q, phase_set, to_set, accept;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] data_q;
  logic [BL_W-1:0]   user_q;
  logic              timeout_q;

  assign accept      = req_valid_i && (state_q == ST_IDLE);
  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign timer_run_o = (state_q == ST_PRE_WAIT) || (state_q == ST_POST_WAIT);
  assign timer_clr_o = (state_d != state_q);

  always_comb begin
    state_d    = state_q;
    bell_set_o = 1'b0;
    phase_set  = 1'b0;
    to_set     = 1'b0;
    case (state_q)
      ST_IDLE:
        if (req_valid_i)
          state_d = (!running_i || req_i.kind == REQ_NOP) ? ST_DONE : ST_PRE_WAIT;
      ST_PRE_WAIT:
        if (tick_i) begin
          if (!bell_i) begin
            if (req_q.kind == REQ_BLIGHT && phase_bl_q) state_d = ST_WR_USER;
            else if (req_q.kind == REQ_LEVEL)           state_d = ST_WR_CMD;
            else                                        state_d = ST_WR_DATA;
          end else if (last_i) begin
            state_d = ST_DONE;
            to_set  = 1'b1;
          end
        end
      ST_WR_USER: state_d = ST_WR_DATA;
      ST_WR_DATA: state_d = ST_WR_CMD;
      ST_WR_CMD:  state_d = ST_RING;
      ST_RING: begin
        bell_set_o = 1'b1;
        state_d    = ST_POST_WAIT;
      end
      ST_POST_WAIT:
        if (tick_i) begin
          if (!bell_i) begin
            if (req_q.kind == REQ_BLIGHT && !phase_bl_q) begin
              state_d   = ST_PRE_WAIT;
              phase_set = 1'b1;
            end else begin
              state_d = ST_DONE;
            end
          end else if (last_i) begin
            state_d = ST_DONE;
            to_set  = 1'b1;
          end
        end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      req_q      <= '0;
      phase_bl_q <= 1'b0;
      timeout_q  <= 1'b0;
      cmd_q      <= '0;
      data_q     <= '0;
      user_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        req_q      <= req_i;
        phase_bl_q <= 1'b0;
        timeout_q  <= 1'b0;
      end
      if (to_set)    timeout_q  <= 1'b1;
      if (phase_set) phase_bl_q <= 1'b1;
      case (state_q)
        ST_WR_USER: user_q <= req_q.bl;
        ST_WR_DATA:
          if (phase_bl_q) data_q <= (req_q.ctrl == 8'd0) ? '0 : req_q.ramp;
          else            data_q <= RAMP_BOUND;
        ST_WR_CMD:
          if (req_q.kind == REQ_LEVEL) begin
            cmd_q[7:0]   <= OP_LEVEL;
            cmd_q[23:16] <= req_q.level;
          end else if (phase_bl_q) begin
            cmd_q[7:0]   <= OP_BLIGHT;
          end else begin
            cmd_q[7:0]   <= OP_PIPE;
            cmd_q[15:8]  <= req_q.ctrl;
          end
        default: ;
      endcase
    end
  end

  assign cmd_o     = cmd_q;
  assign data_o    = data_q;
  assign user_o    = user_q;
  assign timeout_o = timeout_q;

  // R7: ring only with the doorbell clear; command written only with it clear
  a_r7_ring_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bell_set_o |-> !bell_i);
  a_r7_cmd_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR_CMD) |-> !bell_i);
  // R2: skipped request completes next cycle with mailbox untouched
  a_r2_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (!running_i || req_i.kind == REQ_NOP)) |=> (done_o && $stable(cmd_q) && $stable(data_q)));
  // R8: done is a single pulse followed by idle
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));
  // R11: timeout sticky until next acceptance
  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_q && !accept) |=> timeout_q);
  // R1: request held stable while busy
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o) |=> $stable(req_q));
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_seq_pkg::*;
#(
  parameter int POLL_LIMIT    = 80000,
  parameter int POLL_INTERVAL = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [1:0]  req_kind_i,
  input  logic [7:0]  req_ctrl_id_i,
  input  logic [7:0]  req_level_i,
  input  logic [16:0] req_bl_i,
  input  logic [31:0] req_ramp_i,
  input  logic        mcu_running_i,
  input  logic        bell_clr_i,
  output logic        bell_o,
  output logic [31:0] cmd_o,
  output logic [31:0] data_o,
  output logic [16:0] user_lvl_o,
  output logic        done_o,
  output logic        timeout_o
);
  req_t req;
  logic tick, last, timer_clr, timer_run, bell_set;

  assign req.kind  = req_kind_e'(req_kind_i);
  assign req.ctrl  = req_ctrl_id_i;
  assign req.level = req_level_i;
  assign req.bl    = req_bl_i;
  assign req.ramp  = req_ramp_i;

  mbox_seq_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_i       (req),
    .running_i   (mcu_running_i),
    .req_ready_o (req_ready_o),
    .bell_i      (bell_o),
    .tick_i      (tick),
    .last_i      (last),
    .timer_clr_o (timer_clr),
    .timer_run_o (timer_run),
    .bell_set_o  (bell_set),
    .cmd_o       (cmd_o),
    .data_o      (data_o),
    .user_o      (user_lvl_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o)
  );

  mbox_poll_timer #(
    .POLL_LIMIT    (POLL_LIMIT),
    .POLL_INTERVAL (POLL_INTERVAL)
  ) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (timer_clr),
    .run_i  (timer_run),
    .tick_o (tick),
    .last_o (last)
  );

  mbox_doorbell i_bell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (bell_set),
    .clr_i  (bell_clr_i),
    .bell_o (bell_o)
  );
endmodule

// File: tb/test_mbox_cmd_seq.sv
module test_mbox_cmd_seq;
  localparam int LIM = 16;
  localparam int INTV = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [1:0] req_kind_i = '0;
  logic [7:0] req_ctrl_id_i = '0, req_level_i = '0;
  logic [16:0] req_bl_i = '0;
  logic [31:0] req_ramp_i = '0;
  logic mcu_running_i = 1'b1, bell_clr_i = 1'b0, bell_o;
  logic [31:0] cmd_o, data_o;
  logic [16:0] user_lvl_o;
  logic done_o, timeout_o;

  mbox_cmd_seq #(.POLL_LIMIT(LIM), .POLL_INTERVAL(INTV)) i_mbox_cmd_seq (.*);

  always #2.5 clk_i = ~clk_i;

  int errs = 0, checks = 0, cyc = 0;
  int ring_n = 0, dly = 0;
  bit stuck = 1'b0, bell_prev = 1'b0;
  logic [31:0] rc [0:255];
  logic [31:0] rd [0:255];
  logic [16:0] ru [0:255];
  int          rcyc [0:255];
  logic [31:0] exp_cmd = '0;
  int acc_cyc, done_cyc, r0;
  logic [31:0] c0, d0;
  logic [16:0] u0;

  function automatic int to_delay();
    return (LIM - 1) * INTV + 1;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(posedge clk_i) if (cyc > 100000) begin
    errs++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  // microcontroller model and ring monitor
  always @(negedge clk_i) if (rst_ni) begin
    if (bell_o && !bell_prev) begin
      rc[ring_n[7:0]] = cmd_o; rd[ring_n[7:0]] = data_o;
      ru[ring_n[7:0]] = user_lvl_o; rcyc[ring_n[7:0]] = cyc;
      ring_n++;
    end
    bell_prev = bell_o;
    if (bell_clr_i) begin
      bell_clr_i = 1'b0;
      chk(bell_o == 1'b0, "R12 bell after clear", bell_o, 0);
    end else if (bell_o && !stuck) begin
      if (dly == 0) begin bell_clr_i = 1'b1; dly = $urandom_range(0, 4); end
      else dly--;
    end
  end

  task automatic issue(input logic [1:0] k, input logic [7:0] c, input logic [7:0] l,
                       input logic [16:0] b, input logic [31:0] rp, input bit run, input bit hold);
    while (!req_ready_o) @(negedge clk_i);
    r0 = ring_n; c0 = cmd_o; d0 = data_o; u0 = user_lvl_o;
    req_valid_i = 1'b1; req_kind_i = k; req_ctrl_id_i = c; req_level_i = l;
    req_bl_i = b; req_ramp_i = rp; mcu_running_i = run;
    @(negedge clk_i);
    acc_cyc = cyc;
    if (hold) begin
      req_kind_i = 2'd1; req_ctrl_id_i = 8'h5A; req_level_i = 8'hC3;
      for (int i = 0; i < 2; i++) begin
        chk(req_ready_o == 1'b0, "R1 busy not ready", req_ready_o, 0);
        @(negedge clk_i);
      end
    end
    req_valid_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    done_cyc = cyc;
  endtask

  task automatic run_req(input logic [1:0] k, input logic [7:0] c, input logic [7:0] l,
                         input logic [16:0] b, input logic [31:0] rp, input bit run, input bit hold);
    logic [31:0] e;
    issue(k, c, l, b, rp, run, hold);
    if (!run || k == 2'd3) begin
      chk(done_cyc == acc_cyc, "R2 skip done timing", done_cyc - acc_cyc, 0);
      chk(ring_n == r0, "R2 no ring", ring_n - r0, 0);
      chk(cmd_o == c0 && data_o == d0 && user_lvl_o == u0, "R2 no writes", cmd_o, c0);
      chk(timeout_o == 1'b0, "R2 no timeout", timeout_o, 0);
      return;
    end
    chk(timeout_o == 1'b0, "R8 success no timeout", timeout_o, 0);
    case (k)
      2'd0: begin
        e = {exp_cmd[31:16], c, 8'h66};
        chk(ring_n == r0 + 1, "R4 pipe rings", ring_n - r0, 1);
        chk(rc[r0[7:0]] == e, "R3 R4 pipe cmd", rc[r0[7:0]], e);
        chk(rd[r0[7:0]] == 32'hFFFF, "R4 pipe data", rd[r0[7:0]], 32'hFFFF);
        chk(ru[r0[7:0]] == u0, "R4 user untouched", ru[r0[7:0]], u0);
      end
      2'd1: begin
        e = {exp_cmd[31:24], l, exp_cmd[15:8], 8'h65};
        chk(ring_n == r0 + 1, "R5 level rings", ring_n - r0, 1);
        chk(rc[r0[7:0]] == e, "R3 R5 level cmd", rc[r0[7:0]], e);
        chk(rd[r0[7:0]] == d0 && ru[r0[7:0]] == u0, "R5 data user kept", rd[r0[7:0]], d0);
      end
      default: begin
        e = {exp_cmd[31:16], c, 8'h66};
        chk(ring_n == r0 + 2, "R6 two rings", ring_n - r0, 2);
        chk(rc[r0[7:0]] == e && rd[r0[7:0]] == 32'hFFFF, "R6 pipe first", rc[r0[7:0]], e);
        e = {exp_cmd[31:16], c, 8'h67};
        chk(rc[(r0+1)%256] == e, "R3 R6 backlight cmd", rc[(r0+1)%256], e);
        chk(ru[(r0+1)%256] == b, "R6 user level", ru[(r0+1)%256], b);
        chk(rd[(r0+1)%256] == ((c == 8'd0) ? 32'd0 : rp), "R6 ramp", rd[(r0+1)%256], (c == 8'd0) ? 32'd0 : rp);
        chk(rcyc[(r0+1)%256] > rcyc[r0[7:0]], "R7 ring order", rcyc[(r0+1)%256], rcyc[r0[7:0]]);
      end
    endcase
    exp_cmd = e;
    chk(cmd_o == exp_cmd, "R8 final cmd", cmd_o, exp_cmd);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !done_o && !timeout_o && !bell_o, "reset flags", {req_ready_o, done_o, timeout_o, bell_o}, 4'b1000);
    chk(cmd_o == 0 && data_o == 0 && user_lvl_o == 0, "reset regs", cmd_o, 0);

    run_req(2'd0, 8'h03, 8'h00, 17'h0, 32'h0, 1'b1, 1'b1);   // R1 hold while busy
    run_req(2'd1, 8'h00, 8'h2A, 17'h0, 32'h0, 1'b1, 1'b0);
    run_req(2'd0, 8'hFF, 8'h00, 17'h0, 32'h0, 1'b1, 1'b0);   // R4 immediate disable id
    run_req(2'd2, 8'h00, 8'h00, 17'h10000, 32'hDEAD_BEEF, 1'b1, 1'b0); // R6 ramp zeroed
    run_req(2'd2, 8'h02, 8'h00, 17'h0ABCD, 32'h0000_1234, 1'b1, 1'b0);
    run_req(2'd1, 8'h00, 8'h77, 17'h0, 32'h0, 1'b0, 1'b0);   // R2 not running
    run_req(2'd3, 8'h11, 8'h22, 17'h1, 32'h5, 1'b1, 1'b0);   // R2 no-op kind

    // R9: stuck after ring
    stuck = 1'b1;
    issue(2'd1, 8'h00, 8'h19, 17'h0, 32'h0, 1'b1, 1'b0);
    chk(ring_n == r0 + 1, "R9 rang once", ring_n - r0, 1);
    chk(done_cyc - rcyc[r0[7:0]] == to_delay(), "R9 post-wait timeout timing", done_cyc - rcyc[r0[7:0]], to_delay());
    chk(timeout_o == 1'b1, "R9 timeout set", timeout_o, 1);
    exp_cmd = {exp_cmd[31:24], 8'h19, exp_cmd[15:8], 8'h65};
    // R10: stuck before write
    issue(2'd2, 8'h04, 8'h00, 17'h1FFFF, 32'h9, 1'b1, 1'b0);
    chk(done_cyc - acc_cyc == to_delay(), "R9 R10 pre-wait timeout timing", done_cyc - acc_cyc, to_delay());
    chk(ring_n == r0, "R10 no ring", ring_n - r0, 0);
    chk(cmd_o == c0 && data_o == d0 && user_lvl_o == u0, "R10 no writes", cmd_o, c0);
    repeat (5) @(negedge clk_i);
    chk(timeout_o == 1'b1, "R11 sticky", timeout_o, 1);
    stuck = 1'b0;
    while (bell_o) @(negedge clk_i);
    run_req(2'd1, 8'h00, 8'h05, 17'h0, 32'h0, 1'b1, 1'b0);
    chk(timeout_o == 1'b0, "R11 cleared by next request", timeout_o, 0);

    for (int n = 0; n < 40; n++) begin
      logic [1:0] k;
      logic [7:0] c;
      k = 2'($urandom_range(0, 2));
      c = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom);
      run_req(k, c, 8'($urandom), 17'($urandom), $urandom, $urandom_range(0, 7) != 0, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule